// File: doc/BRIEF.md
# Multi-Mode Input Glitch Filter

This block conditions a single asynchronous input pin before edge detection. The pin first passes through a two-flop synchronizer. One of four filtering modes then decides when the filtered level may follow the synchronized signal. The modes are a pass-through, a two-sample vote, a three-sample vote and a continuous-stability check.

Sampling is paced by a filter tick. The tick comes from a source clock enable, which runs at either the full system rate or half of it. A power-of-two prescaler divides that enable down to the tick rate. The block's outputs are the filtered level and a one-cycle strobe for each rising and each falling change of that level. A timer or capture unit downstream uses these outputs in place of the raw pin.

Top module: `glitch_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `filt_out`, `rise_pls` and `fall_pls` are 0.
- R2: The pin passes through a two-flop synchronizer. In bypass mode, a pin change made before clock edge k appears on `filt_out` after edge k+1, with the matching strobe in that same cycle.
- R3: The mode encoding on `mode_sel` is as follows:
  - 2'b00: two agreeing consecutive tick samples.
  - 2'b01: bypass, with the synchronizer output used unfiltered.
  - 2'b10: three agreeing consecutive tick samples.
  - 2'b11: continuous stability.
  - 2'b00 is the value to drive out of reset.
- R4: The tick period T, in system clocks, depends on the prescale field P (`presc_sel`, 0..7) and `fast_src`. T is 2^(P+1) when `fast_src`=0 (half-rate source) and 2^P when `fast_src`=1 (full-rate source). With the half-rate source, two ticks are never in adjacent cycles.
- R5: In two-sample mode, a pulse of 2T clocks or more always passes and a pulse of T clocks or less is always rejected. For example, with `fast_src`=0 and P=0 the figures are 4 and 2 clocks; with `fast_src`=1 they are 2 and 1.
- R6: In three-sample mode, a pulse of 3T clocks or more always passes and a pulse of 2T clocks or less is always rejected.
- R7: In continuous mode, the input is sampled on every source-clock enable. The level updates at a tick only if every sample taken since the previous tick, including the tick's own sample, agrees. Pulses of at least 2T-1 clocks pass; pulses shorter than the span of one interval's samples are rejected.
- R8: `rise_pls` and `fall_pls` each last exactly one system clock. They fire only when `filt_out` changes, with one rise and one fall for each accepted pulse.
- R9: A change of `presc_sel` or `fast_src` restarts the prescaler count, so the first tick under the new setting falls a full new period later. In the filtering modes, the internal filtered level changes only on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Raw asynchronous pin |
| mode_sel | input | 2 | Filter mode select |
| presc_sel | input | PSEL_W (3) | Tick prescale exponent |
| fast_src | input | 1 | 1 selects the full-rate source, 0 the half-rate source |
| filt_out | output | 1 | Filtered level |
| rise_pls | output | 1 | One-cycle strobe on a rising filtered level |
| fall_pls | output | 1 | One-cycle strobe on a falling filtered level |

## Verification
The embedded properties check four things on every cycle:
- the prescaler count stays within its limit for the current setting;
- with the half-rate source, ticks are never adjacent;
- the filtered level holds between ticks, and a rise strobe never repeats in the next cycle;
- in bypass mode, the rise strobe tracks the synchronizer output.

The pulse-width guarantees of each mode can only be shown by the directed scenarios. These sweep pulse widths on both sides of each limit, over several phases against the tick. The same holds for the exact latency after a prescale change and for the rejection of a chopped waveform in continuous mode.

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic [1:0]        mode_sel,
  input  logic [PSEL_W-1:0] presc_sel,
  input  logic              fast_src,
  output logic              filt_out,
  output logic              rise_pls,
  output logic              fall_pls
);
  localparam int CNT_W = (1 << PSEL_W) - 1;
  localparam logic [1:0] M_TWO = 2'b00, M_BYP = 2'b01, M_THREE = 2'b10, M_CONT = 2'b11;

  logic s1, s2, hph, fast_q;
  logic [PSEL_W-1:0] presc_q;
  logic [CNT_W-1:0]  pcnt, lim;
  logic [CNT_W:0]    one_sh;
  logic cfg_chg, src_en, tick;
  logic h0, h1, filt_q, filt_prev;
  logic c_first, c_bad, c_val;

  assign one_sh  = (CNT_W+1)'(1) << presc_sel;
  assign lim     = CNT_W'(one_sh - (CNT_W+1)'(1));
  assign cfg_chg = (presc_sel != presc_q) || (fast_src != fast_q);
  assign src_en  = fast_src | hph;
  assign tick    = src_en && !cfg_chg && (pcnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hph     <= 1'b0;
      fast_q  <= 1'b0;
      presc_q <= '0;
      pcnt    <= '0;
    end else begin
      hph     <= ~hph;
      fast_q  <= fast_src;
      presc_q <= presc_sel;
      if (cfg_chg)     pcnt <= '0;
      else if (tick)   pcnt <= '0;
      else if (src_en) pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h0     <= 1'b0;
      h1     <= 1'b0;
      filt_q <= 1'b0;
    end else if (tick) begin
      h0 <= s2;
      h1 <= h0;
      case (mode_sel)
        M_TWO:   if (s2 == h0) filt_q <= s2;
        M_THREE: if (s2 == h0 && h0 == h1) filt_q <= s2;
        M_CONT:  if (!c_bad && (c_first || s2 == c_val)) filt_q <= s2;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_first <= 1'b1;
      c_bad   <= 1'b0;
      c_val   <= 1'b0;
    end else if (src_en) begin
      if (tick) begin
        c_first <= 1'b1;
        c_bad   <= 1'b0;
      end else if (c_first) begin
        c_val   <= s2;
        c_first <= 1'b0;
      end else if (s2 != c_val) begin
        c_bad <= 1'b1;
      end
    end
  end

  assign filt_out = (mode_sel == M_BYP) ? s2 : filt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) filt_prev <= 1'b0;
    else        filt_prev <= filt_out;
  end

  assign rise_pls = filt_out & ~filt_prev;
  assign fall_pls = ~filt_out & filt_prev;

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> pcnt <= lim);

  a_r4_slow_no_adjacent_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fast_src) |=> (fast_src || !tick));

  a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(filt_q));

  a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pls |=> !rise_pls);

  a_r2_bypass_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_BYP && $past(mode_sel) == M_BYP) |-> (rise_pls == (s2 && !$past(s2))));
endmodule

// File: tb/glitch_filter_tb.sv
module glitch_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [2:0] presc_sel = 3'd0;
  logic fast_src = 1'b0;
  logic filt_out, rise_pls, fall_pls;

  int n_chk = 0;
  int n_bad = 0;
  int rc = 0;
  int fc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  glitch_filter u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode_sel(mode_sel),
    .presc_sel(presc_sel), .fast_src(fast_src),
    .filt_out(filt_out), .rise_pls(rise_pls), .fall_pls(fall_pls)
  );

  always @(negedge clk) if (rst_n) begin
    rc += int'(rise_pls);
    fc += int'(fall_pls);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_pulse(input logic [1:0] m, input int p, input bit f,
                           input int w, input int exp, input string tag);
    int t;
    t = (1 << p) * (f ? 1 : 2);
    mode_sel = m; presc_sel = 3'(p); fast_src = f; pin_in = 1'b0;
    step(4 * t + 16);
    for (int ph = 0; ph < 4; ph++) begin
      step(ph);
      rc = 0; fc = 0;
      pin_in = 1'b1;
      step(w);
      pin_in = 1'b0;
      step(4 * t + 16);
      check(rc == exp, {tag, " rises"}, rc, exp);
      check(fc == exp, {tag, " falls"}, fc, exp);
      check(filt_out == 1'b0, {tag, " level"}, int'(filt_out), 0);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pin_in = 1'b1; mode_sel = 2'b01;
    step(5);
    check(filt_out == 1'b0, "R1 level in reset", int'(filt_out), 0);
    check(rise_pls == 1'b0 && fall_pls == 1'b0, "R1 strobes in reset", int'(rise_pls | fall_pls), 0);
    pin_in = 1'b0; mode_sel = 2'b00;
    rst_n = 1'b1;
    step(1);
    check(filt_out == 1'b0, "R1 level after reset", int'(filt_out), 0);
  endtask

  task automatic t_bypass;
    mode_sel = 2'b01; pin_in = 1'b0;
    step(5);
    pin_in = 1'b1;
    step(1);
    check(filt_out == 1'b0, "R2 one edge", int'(filt_out), 0);
    step(1);
    check(filt_out == 1'b1, "R2 two edges", int'(filt_out), 1);
    check(rise_pls == 1'b1, "R2 rise strobe", int'(rise_pls), 1);
    step(1);
    check(rise_pls == 1'b0, "R8 rise one cycle", int'(rise_pls), 0);
    pin_in = 1'b0;
    step(2);
    check(fall_pls == 1'b1 && filt_out == 1'b0, "R2 fall strobe", int'(fall_pls), 1);
    step(1);
    check(fall_pls == 1'b0, "R8 fall one cycle", int'(fall_pls), 0);
  endtask

  task automatic t_restart;
    mode_sel = 2'b00; fast_src = 1'b1; presc_sel = 3'd7; pin_in = 1'b0;
    step(300);
    pin_in = 1'b1; presc_sel = 3'd3;
    step(16);
    check(filt_out == 1'b0, "R9 before first full period", int'(filt_out), 0);
    step(1);
    check(filt_out == 1'b1, "R9 tick after restart", int'(filt_out), 1);
    check(rise_pls == 1'b1, "R9 rise strobe", int'(rise_pls), 1);
    pin_in = 1'b0;
    step(40);
  endtask

  task automatic t_chopped;
    mode_sel = 2'b11; fast_src = 1'b1; presc_sel = 3'd2; pin_in = 1'b0;
    step(30);
    rc = 0;
    for (int i = 0; i < 10; i++) begin
      pin_in = 1'b1; step(2);
      pin_in = 1'b0; step(1);
    end
    step(20);
    check(rc == 0, "R7 chopped input rejected", rc, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bypass();
    run_pulse(2'b00, 0, 1'b0, 4, 1, "R5 two slow p0 w4");
    run_pulse(2'b00, 0, 1'b0, 2, 0, "R5 two slow p0 w2");
    run_pulse(2'b00, 0, 1'b1, 2, 1, "R5 two fast p0 w2");
    run_pulse(2'b00, 0, 1'b1, 1, 0, "R5 two fast p0 w1");
    run_pulse(2'b00, 2, 1'b0, 16, 1, "R4 two slow p2 w16");
    run_pulse(2'b00, 2, 1'b0, 8, 0, "R4 two slow p2 w8");
    run_pulse(2'b10, 0, 1'b0, 6, 1, "R6 three slow p0 w6");
    run_pulse(2'b10, 0, 1'b0, 4, 0, "R6 three slow p0 w4");
    run_pulse(2'b10, 3, 1'b1, 24, 1, "R6 three fast p3 w24");
    run_pulse(2'b10, 3, 1'b1, 16, 0, "R3 three fast p3 w16");
    run_pulse(2'b11, 2, 1'b1, 8, 1, "R7 cont fast p2 w8");
    run_pulse(2'b11, 2, 1'b1, 3, 0, "R7 cont fast p2 w3");
    run_pulse(2'b11, 1, 1'b0, 7, 1, "R7 cont slow p1 w7");
    run_pulse(2'b11, 1, 1'b0, 2, 0, "R7 cont slow p1 w2");
    t_chopped();
    t_restart();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule